// File: doc/BRIEF.md
# Receive Sample Source Selector

This block sits at the head of a receive sample path and decides what the downstream chain sees. A small mode register, loaded through a single-cycle write port, selects one of four sources. The sources are live converter I/Q samples, the transmit I/Q samples looped back digitally, a 16-bit counting pattern, or a 32-bit counting pattern whose halves share one output sample. Every source is paced by the same input sample strobe. Each accepted sample appears on registered 16-bit I/Q outputs together with a valid pulse one clock later.

The counting patterns are built-in test sources. They let software confirm sample ordering, dropped samples and word alignment across the rest of the receive chain without any analog input. A synchronous receive reset clears the pattern counter and the output stage without disturbing the selected mode.

Top module: `rx_source_select`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `out_i` and `out_q` are 0, and the mode register holds 0, which selects normal operation.
- R2: With mode 0, a cycle with `sample_stb` high makes `out_i`/`out_q` equal to that cycle's `adc_i`/`adc_q` in the following cycle.
- R3: With mode bit 0 set and mode bit 1 clear, a strobed sample outputs that cycle's `tx_i`/`tx_q`.
- R4: With mode bit 1 set and bit 2 clear, a strobed sample outputs the counter's low 16 bits on both `out_i` and `out_q`, and the counter then adds one.
- R5: With mode bits 1 and 2 both set, a strobed sample outputs counter bits 15:0 on `out_i` and bits 31:16 on `out_q`, and the counter adds one, carrying from the low half into the high half.
- R6: The counter advances only in cycles where `sample_stb` is high and counting is selected. In a cycle without a strobe, `out_valid` goes low and `out_i`/`out_q` hold their values.
- R7: When bits 0 and 1 are both set, the counting pattern is output and the loopback data is not.
- R8: A write to the mode register that sets bit 1 while bit 1 was clear resets the counter to 0. A write that keeps bit 1 set leaves the counter running.
- R9: A cycle with `rx_reset` high clears the counter, `out_i`, `out_q` and `out_valid` in the next cycle and outputs no sample for a strobe in that cycle. The mode register is unchanged.
- R10: The mode register is at write address 13. A write to any other address leaves the mode and the output sources unchanged.
- R11: Mode bit 2 with bit 1 clear has no effect on the selected source.
- R12: `out_valid` is high in exactly the cycles that follow a cycle with `sample_stb` high and `rx_reset` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_reset | input | 1 | Synchronous receive-path reset |
| cfg_wr_en | input | 1 | Write strobe of the configuration port |
| cfg_wr_addr | input | 5 | Write address; the mode register sits at 13 |
| cfg_wr_data | input | 32 | Write data; bits 2:0 hold the mode |
| sample_stb | input | 1 | One-cycle pulse marking a new input sample |
| adc_i | input | 16 | Converter in-phase sample |
| adc_q | input | 16 | Converter quadrature sample |
| tx_i | input | 16 | Transmit in-phase sample for loopback |
| tx_q | input | 16 | Transmit quadrature sample for loopback |
| out_i | output | 16 | Selected in-phase sample |
| out_q | output | 16 | Selected quadrature sample |
| out_valid | output | 1 | Pulse marking a new output sample |

## Verification
The bench drives a long 32-bit counting run past 65535 samples. A design that fails to carry into the high half, or that swaps the halves between I and Q, shows a wrong `out_q` at the wrap. It sets loopback and counting together to catch a multiplexer with reversed priority. It rewrites an active counting mode to catch a counter that restarts on every write rather than on entry. Writes to a neighbouring address and a lone bit 2 expose a loose address or mode decode. Gaps between strobes and receive resets mixed into random traffic expose a counter that runs freely, outputs that drift without a strobe, and a valid pulse at the wrong latency.

// File: rtl/rxsel_pkg.sv
package rxsel_pkg;

  localparam int MODE_BITS = 3;

  // bit 2: wide counter, bit 1: counting, bit 0: loopback
  typedef struct packed {
    logic cnt32;
    logic count;
    logic loopback;
  } mode_t;

  typedef enum logic [1:0] {
    SRC_ADC   = 2'd0,
    SRC_LOOP  = 2'd1,
    SRC_CNT16 = 2'd2,
    SRC_CNT32 = 2'd3
  } src_t;

  function automatic src_t decode_src(input mode_t m);
    if (m.count)         return m.cnt32 ? SRC_CNT32 : SRC_CNT16;
    else if (m.loopback) return SRC_LOOP;
    else                 return SRC_ADC;
  endfunction

endpackage

// File: rtl/rxsel_rst_sync.sv
module rxsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxsel_mode_reg.sv
module rxsel_mode_reg
  import rxsel_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int MODE_ADDR = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mode_t             mode_o,
  output logic              count_entry_o
);

  logic  hit;
  mode_t mode_q;
  mode_t mode_d;
  logic  entry;
  logic  unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:MODE_BITS];

  always_comb begin
    hit    = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
    mode_d = mode_q;
    entry  = 1'b0;
    if (hit) begin
      mode_d = mode_t'(wr_data[MODE_BITS-1:0]);
      entry  = mode_d.count && !mode_q.count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mode_q <= '0;
    else if (hit) mode_q <= mode_d;
  end

  assign mode_o        = mode_q;
  assign count_entry_o = entry;

  p_other_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr != ADDR_W'(MODE_ADDR)) |=> $stable(mode_q));

  p_write_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(MODE_ADDR)) |=>
      (mode_q == $past(wr_data[MODE_BITS-1:0])));

endmodule

// File: rtl/rxsel_pattern_cnt.sv
module rxsel_pattern_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_reset,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = rx_reset || clear || advance;
    if (rx_reset || clear) cnt_d = '0;
    else                   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && !rx_reset) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_cnt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear && !rx_reset) |=> $stable(cnt_q));

  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_reset || clear) |=> (cnt_q == '0));

endmodule

// File: rtl/rxsel_out_stage.sv
module rxsel_out_stage
  import rxsel_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_reset,
  input  logic                strobe,
  input  src_t                src,
  input  logic [SAMPLE_W-1:0] adc_i,
  input  logic [SAMPLE_W-1:0] adc_q,
  input  logic [SAMPLE_W-1:0] tx_i,
  input  logic [SAMPLE_W-1:0] tx_q,
  input  logic [CNT_W-1:0]    cnt,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic                out_valid
);

  logic [SAMPLE_W-1:0] sel_i;
  logic [SAMPLE_W-1:0] sel_q;
  logic [SAMPLE_W-1:0] i_q;
  logic [SAMPLE_W-1:0] q_q;
  logic [SAMPLE_W-1:0] i_d;
  logic [SAMPLE_W-1:0] q_d;
  logic                v_q;
  logic                v_d;
  logic                data_en;

  always_comb begin
    unique case (src)
      SRC_LOOP:  begin sel_i = tx_i;                  sel_q = tx_q;                        end
      SRC_CNT16: begin sel_i = cnt[SAMPLE_W-1:0];     sel_q = cnt[SAMPLE_W-1:0];           end
      SRC_CNT32: begin sel_i = cnt[SAMPLE_W-1:0];     sel_q = cnt[2*SAMPLE_W-1:SAMPLE_W];  end
      default:   begin sel_i = adc_i;                 sel_q = adc_q;                       end
    endcase
  end

  always_comb begin
    data_en = rx_reset || strobe;
    v_d     = strobe && !rx_reset;
    i_d     = rx_reset ? '0 : sel_i;
    q_d     = rx_reset ? '0 : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      q_q <= '0;
    end else if (data_en) begin
      i_q <= i_d;
      q_q <= q_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  assign out_i     = i_q;
  assign out_q     = q_q;
  assign out_valid = v_q;

  p_valid_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !rx_reset) |=> out_valid);

  p_no_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe || rx_reset) |=> !out_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !rx_reset) |=> ($stable(out_i) && $stable(out_q)));

endmodule

// File: rtl/rx_source_select.sv
module rx_source_select
  import rxsel_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int MODE_ADDR = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_reset,
  input  logic                cfg_wr_en,
  input  logic [ADDR_W-1:0]   cfg_wr_addr,
  input  logic [DATA_W-1:0]   cfg_wr_data,
  input  logic                sample_stb,
  input  logic [SAMPLE_W-1:0] adc_i,
  input  logic [SAMPLE_W-1:0] adc_q,
  input  logic [SAMPLE_W-1:0] tx_i,
  input  logic [SAMPLE_W-1:0] tx_q,
  output logic [SAMPLE_W-1:0] out_i,
  output logic [SAMPLE_W-1:0] out_q,
  output logic                out_valid
);

  localparam int CNT_W = 2 * SAMPLE_W;

  logic             rst_sync_n;
  mode_t            mode;
  logic             count_entry;
  logic             advance;
  logic [CNT_W-1:0] cnt;
  src_t             src;

  rxsel_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxsel_mode_reg #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MODE_ADDR (MODE_ADDR)
  ) u_mode (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_en         (cfg_wr_en),
    .wr_addr       (cfg_wr_addr),
    .wr_data       (cfg_wr_data),
    .mode_o        (mode),
    .count_entry_o (count_entry)
  );

  assign advance = sample_stb && mode.count;
  assign src     = decode_src(mode);

  rxsel_pattern_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rx_reset (rx_reset),
    .clear    (count_entry),
    .advance  (advance),
    .cnt_o    (cnt)
  );

  rxsel_out_stage #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rx_reset  (rx_reset),
    .strobe    (sample_stb),
    .src       (src),
    .adc_i     (adc_i),
    .adc_q     (adc_q),
    .tx_i      (tx_i),
    .tx_q      (tx_q),
    .cnt       (cnt),
    .out_i     (out_i),
    .out_q     (out_q),
    .out_valid (out_valid)
  );

  p_count_prio_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_stb && !rx_reset && mode.count) |=>
      (out_i == $past(cnt[SAMPLE_W-1:0])));

  p_wide_high_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_stb && !rx_reset && mode.count && mode.cnt32) |=>
      (out_q == $past(cnt[CNT_W-1:SAMPLE_W])));

  p_normal_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_stb && !rx_reset && !mode.count && !mode.loopback) |=>
      (out_i == $past(adc_i) && out_q == $past(adc_q)));

endmodule

// File: tb/rx_source_select_tb.sv
module rx_source_select_tb;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_reset;
  logic        cfg_wr_en;
  logic [4:0]  cfg_wr_addr;
  logic [31:0] cfg_wr_data;
  logic        sample_stb;
  logic [15:0] adc_i, adc_q, tx_i, tx_q;
  logic [15:0] out_i, out_q;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [2:0]  m_mode;
  logic [31:0] m_cnt;
  logic [15:0] e_i, e_q;
  logic        e_v;

  always #(CLK_NS/2) clk = ~clk;

  rx_source_select u_dut (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .sample_stb(sample_stb), .adc_i(adc_i), .adc_q(adc_q), .tx_i(tx_i), .tx_q(tx_q),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "out_valid", {31'd0, out_valid}, {31'd0, e_v});
    chk(tag, "out_i", {16'd0, out_i}, {16'd0, e_i});
    chk(tag, "out_q", {16'd0, out_q}, {16'd0, e_q});
  endtask

  // one clock: drive at negedge, model the edge, check after it
  task automatic tick(input logic stb, input logic [15:0] ai, input logic [15:0] aq,
                      input logic [15:0] ti, input logic [15:0] tq, input logic rr,
                      input logic we, input logic [4:0] wa, input logic [31:0] wd,
                      input string tag);
    logic hit;
    @(negedge clk);
    sample_stb = stb; adc_i = ai; adc_q = aq; tx_i = ti; tx_q = tq;
    rx_reset = rr; cfg_wr_en = we; cfg_wr_addr = wa; cfg_wr_data = wd;
    hit = we && (wa == 5'd13);
    if (rr) begin
      e_v = 1'b0; e_i = '0; e_q = '0;
    end else begin
      e_v = stb;
      if (stb) begin
        if (m_mode[1]) begin
          e_i = m_cnt[15:0];
          e_q = m_mode[2] ? m_cnt[31:16] : m_cnt[15:0];
        end else if (m_mode[0]) begin
          e_i = ti; e_q = tq;
        end else begin
          e_i = ai; e_q = aq;
        end
      end
    end
    if (rr || (hit && wd[1] && !m_mode[1])) m_cnt = '0;
    else if (stb && m_mode[1])              m_cnt = m_cnt + 32'd1;
    if (hit) m_mode = wd[2:0];
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  task automatic wr_mode(input logic [4:0] a, input logic [31:0] d, input string tag);
    tick(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic smp(input logic [15:0] ai, input logic [15:0] aq,
                     input logic [15:0] ti, input logic [15:0] tq, input string tag);
    tick(1'b1, ai, aq, ti, tq, 1'b0, 1'b0, 5'd0, 32'd0, tag);
  endtask

  task automatic idle(input string tag);
    tick(1'b0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 5'd0, 32'd0, tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20251);
    rst_n = 1'b0; rx_reset = 1'b0; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
    sample_stb = 1'b0; adc_i = 16'h1111; adc_q = 16'h2222; tx_i = '0; tx_q = '0;
    m_mode = '0; m_cnt = '0; e_i = '0; e_q = '0; e_v = 1'b0;

    // R1: reset state while asserted, even with a strobe present
    sample_stb = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk);
    sample_stb = 1'b0;
    rst_n = 1'b1;
    repeat (3) idle("R1");

    // R2: normal mode carries converter data
    smp(16'h1234, 16'hABCD, 16'h5555, 16'h6666, "R2");
    smp(16'h8000, 16'h7FFF, 16'h0001, 16'h0002, "R2");
    idle("R6");

    // R10: write to a neighbouring address is ignored
    wr_mode(5'd12, 32'h2, "R10");
    smp(16'h0BAD, 16'h0CAB, 16'h1357, 16'h2468, "R10");
    wr_mode(5'd14, 32'h3, "R10");
    smp(16'h4321, 16'h8765, 16'h1357, 16'h2468, "R10");

    // R11: lone wide bit keeps normal mode
    wr_mode(5'd13, 32'h4, "R11");
    smp(16'hFACE, 16'hBEEF, 16'h1357, 16'h2468, "R11");

    // R3: loopback
    wr_mode(5'd13, 32'h1, "R3");
    smp(16'hFACE, 16'hBEEF, 16'hC0DE, 16'hD00D, "R3");
    smp(16'h0000, 16'hFFFF, 16'h0F0F, 16'hF0F0, "R3");

    // R7 and R4: counting beats loopback, 16-bit pattern from zero
    wr_mode(5'd13, 32'h3, "R8");
    smp(16'h1, 16'h2, 16'h3, 16'h4, "R7");
    chk("R4", "first count", {16'd0, out_i}, 32'd0);
    smp(16'h1, 16'h2, 16'h3, 16'h4, "R4");
    smp(16'h1, 16'h2, 16'h3, 16'h4, "R4");

    // R6: gaps do not advance the counter
    idle("R6"); idle("R6"); idle("R6");
    smp(16'h1, 16'h2, 16'h3, 16'h4, "R6");
    chk("R6", "count after gap", {16'd0, out_i}, 32'd3);

    // R8: rewrite with counting still on keeps counting
    wr_mode(5'd13, 32'h2, "R8");
    smp(16'h1, 16'h2, 16'h3, 16'h4, "R8");
    chk("R8", "no restart", {16'd0, out_q}, 32'd4);
    wr_mode(5'd13, 32'h0, "R8");
    wr_mode(5'd13, 32'h2, "R8");
    smp(16'h1, 16'h2, 16'h3, 16'h4, "R8");
    chk("R8", "restart on entry", {16'd0, out_i}, 32'd0);

    // R9: receive reset with a strobe in the same cycle
    smp(16'h1, 16'h2, 16'h3, 16'h4, "R4");
    tick(1'b1, 16'h1, 16'h2, 16'h3, 16'h4, 1'b1, 1'b0, 5'd0, 32'd0, "R9");
    smp(16'h1, 16'h2, 16'h3, 16'h4, "R9");
    chk("R9", "count cleared", {16'd0, out_i}, 32'd0);

    // R5: 32-bit pattern across the carry from low to high half
    wr_mode(5'd13, 32'h0, "R5");
    wr_mode(5'd13, 32'h6, "R5");
    for (int k = 0; k < 65538; k++) smp(16'h0, 16'h0, 16'h0, 16'h0, "R5");
    chk("R5", "low after carry", {16'd0, out_i}, 32'd1);
    chk("R5", "high after carry", {16'd0, out_q}, 32'd1);

    // R12 and mixed traffic: random stimulus against the model
    for (int k = 0; k < 4000; k++) begin
      logic        r_stb, r_rr, r_we;
      logic [4:0]  r_a;
      r_stb = ($urandom % 3) != 0;
      r_rr  = ($urandom % 50) == 0;
      r_we  = ($urandom % 20) == 0;
      r_a   = (($urandom % 4) == 0) ? 5'($urandom) : 5'd13;
      tick(r_stb, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
           r_rr, r_we, r_a, $urandom, "R12");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule